// File: doc/BRIEF.md
# Board System Control Register Bank

This block is the control register bank of a development board, reached through a simple 32-bit slave port inside a 4 KB address window. Software uses it for several jobs. It reads a board identifier fixed at build time. It drives the board LEDs and keeps two scratch configuration words. It manipulates two flag words through separate set-only and clear-only addresses; one word is volatile and one is meant to survive a warm reset. It samples a free-running reference tick counter and reads a handful of constant identification words.

A software key guards the reset control word. Only after the exact key value has been written to the lock register does a write to reset control land. Such a write can also request a system reset. The request is a one-cycle pulse on a dedicated output.

Every access completes in the cycle it is presented. Read data is registered and appears after the clock edge of the read cycle. There are no wait states and no error responses.

Top module: `board_sysctl`

## Requirements
- R1: A read of offset 0x000 returns the BOARD_ID parameter. Offset 0x044 reads 0x00000001, 0x050 reads 0x00001000, 0x084 reads 0x02000000 and 0x088 reads 0xFF000000.
- R2: A write to 0x008 stores the low LED_W bits of the data. These bits drive `led_out` and read back at 0x008, zero-extended.
- R3: Offsets 0x028 and 0x02C are independent 32-bit read/write words.
- R4: The volatile flag word reads at 0x030. A write to 0x030 ORs the data into it, and a write to 0x034 clears every bit that is 1 in the data.
- R5: The non-volatile flag word reads at 0x038. A write to 0x038 sets bits and a write to 0x03C clears bits, in the same way as R4.
- R6: Writing exactly 0x0000A05F to 0x020 stores 0xA05F. Any other write stores only data bits 14:0, so bit 15 reads 0. The register reads back as a 16-bit value, zero-extended.
- R7: A write to 0x040 updates the 32-bit reset level word only while the lock register holds 0xA05F; otherwise the word keeps its value. It reads back at 0x040.
- R8: An accepted reset control write whose data bit 8 is 1 makes `reset_req` high for exactly the one cycle after the write edge. No other write raises it.
- R9: Offset 0x05C reads a CNT_W-bit counter, zero-extended. The counter advances by one every CLK_HZ/TICK_HZ clock cycles and wraps to 0 after 2^CNT_W-1.
- R10: Every other offset reads as 0 and ignores writes. This includes 0x034, 0x03C and any address whose low two bits are not zero.
- R11: A synchronous active-high `rst` clears every register and `bus_rdata`, except the volatile flags, which load 3.
- R12: A read presented with `bus_en` high and `bus_we` low appears on `bus_rdata` after that clock edge. `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_out | output | LED_W | LED register contents |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the bank with CLK_HZ=96 and TICK_HZ=24, a divide ratio of 4, so that the counter step can be predicted exactly from the distance between two reads. It narrows CNT_W to 6, which brings the counter wrap within a few hundred cycles: a 256-cycle gap must return the same value. LED_W=8 shows that upper LED data bits are dropped.

// File: rtl/board_sysctl_pkg.sv
package board_sysctl_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] LOCK_KEY = 32'h0000_A05F;

  // byte offsets of the decoded words
  localparam int OFF_ID      = 'h000;
  localparam int OFF_LED     = 'h008;
  localparam int OFF_LOCK    = 'h020;
  localparam int OFF_CFG0    = 'h028;
  localparam int OFF_CFG1    = 'h02C;
  localparam int OFF_FLG_SET = 'h030;
  localparam int OFF_FLG_CLR = 'h034;
  localparam int OFF_NVF_SET = 'h038;
  localparam int OFF_NVF_CLR = 'h03C;
  localparam int OFF_RSTCTL  = 'h040;
  localparam int OFF_CONST_A = 'h044;
  localparam int OFF_CONST_B = 'h050;
  localparam int OFF_TICK    = 'h05C;
  localparam int OFF_CONST_C = 'h084;
  localparam int OFF_CONST_D = 'h088;

  localparam logic [DATA_W-1:0] VAL_CONST_A = 32'h0000_0001;
  localparam logic [DATA_W-1:0] VAL_CONST_B = 32'h0000_1000;
  localparam logic [DATA_W-1:0] VAL_CONST_C = 32'h0200_0000;
  localparam logic [DATA_W-1:0] VAL_CONST_D = 32'hFF00_0000;

  localparam logic [DATA_W-1:0] FLAGS_RST = 32'h0000_0003;
endpackage

// File: rtl/board_sysctl_lock.sv
module board_sysctl_lock
  import board_sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       lock_q,
  output logic              unlocked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= '0;
    end else if (wr_en) begin
      if (wdata == LOCK_KEY) lock_q <= LOCK_KEY[15:0];
      else                   lock_q <= {1'b0, wdata[14:0]};
    end
  end

  assign unlocked = (lock_q == LOCK_KEY[15:0]);

  // R6: a non-key write always leaves bit 15 low
  a_r6_nonkey_clears_top: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata != LOCK_KEY) |=> !lock_q[15]);
  // R6: the exact key unlocks
  a_r6_key_unlocks: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata == LOCK_KEY) |=> unlocked);
endmodule

// File: rtl/board_sysctl_flags.sv
module board_sysctl_flags #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= RST_VAL;
    else if (set_en) q <= q | wdata;
    else if (clr_en) q <= q & ~wdata;
  end

  // R4 and R5: set writes raise every requested bit
  a_r4_set_bits: assert property (@(posedge clk) disable iff (rst)
    set_en |=> ((q & $past(wdata)) == $past(wdata)));
  // R4 and R5: clear writes drop every requested bit
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !set_en) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/board_sysctl_tick.sv
module board_sysctl_tick #(
  parameter int DIV   = 2,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  generate
    if (DIV <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count + 1'b1;
      end
    end else begin : g_prescaled
      localparam int PRE_W = $clog2(DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);
      logic [PRE_W-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre   <= '0;
          count <= '0;
        end else if (pre == PRE_LAST) begin
          pre   <= '0;
          count <= count + 1'b1;
        end else begin
          pre   <= pre + 1'b1;
        end
      end

      // R9: the counter only moves when the prescaler wraps
      a_r9_step_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> ($past(pre) == PRE_LAST));
    end
  endgenerate
endmodule

// File: rtl/board_sysctl.sv
module board_sysctl
  import board_sysctl_pkg::*;
#(
  parameter logic [31:0] BOARD_ID = 32'h0000_0000,
  parameter int          LED_W    = 8,
  parameter int          ADDR_W   = 12,
  parameter int          CLK_HZ   = 48_000_000,
  parameter int          TICK_HZ  = 24_000_000,
  parameter int          CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [LED_W-1:0]  led_out,
  output logic              reset_req
);
  localparam int TICK_DIV = (CLK_HZ / TICK_HZ) < 1 ? 1 : (CLK_HZ / TICK_HZ);

  logic wr, rd;
  assign wr = bus_en &&  bus_we;
  assign rd = bus_en && !bus_we;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  logic wr_led, wr_lock, wr_cfg0, wr_cfg1, wr_rst;
  logic wr_fset, wr_fclr, wr_nset, wr_nclr;
  assign wr_led  = wr && hit(bus_addr, OFF_LED);
  assign wr_lock = wr && hit(bus_addr, OFF_LOCK);
  assign wr_cfg0 = wr && hit(bus_addr, OFF_CFG0);
  assign wr_cfg1 = wr && hit(bus_addr, OFF_CFG1);
  assign wr_rst  = wr && hit(bus_addr, OFF_RSTCTL);
  assign wr_fset = wr && hit(bus_addr, OFF_FLG_SET);
  assign wr_fclr = wr && hit(bus_addr, OFF_FLG_CLR);
  assign wr_nset = wr && hit(bus_addr, OFF_NVF_SET);
  assign wr_nclr = wr && hit(bus_addr, OFF_NVF_CLR);

  logic [15:0]       lock_q;
  logic              unlocked;
  logic [31:0]       flags_q, nvflags_q;
  logic [CNT_W-1:0]  tick_q;
  logic [LED_W-1:0]  led_q;
  logic [31:0]       cfg0_q, cfg1_q, reset_level;

  board_sysctl_lock u_lock (
    .clk(clk), .rst(rst), .wr_en(wr_lock), .wdata(bus_wdata),
    .lock_q(lock_q), .unlocked(unlocked)
  );

  board_sysctl_flags #(.W(DATA_W), .RST_VAL(FLAGS_RST)) u_flags (
    .clk(clk), .rst(rst), .set_en(wr_fset), .clr_en(wr_fclr),
    .wdata(bus_wdata), .q(flags_q)
  );

  board_sysctl_flags #(.W(DATA_W), .RST_VAL('0)) u_nvflags (
    .clk(clk), .rst(rst), .set_en(wr_nset), .clr_en(wr_nclr),
    .wdata(bus_wdata), .q(nvflags_q)
  );

  board_sysctl_tick #(.DIV(TICK_DIV), .CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst(rst), .count(tick_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q       <= '0;
      cfg0_q      <= '0;
      cfg1_q      <= '0;
      reset_level <= '0;
      reset_req   <= 1'b0;
    end else begin
      if (wr_led)  led_q  <= bus_wdata[LED_W-1:0];
      if (wr_cfg0) cfg0_q <= bus_wdata;
      if (wr_cfg1) cfg1_q <= bus_wdata;
      if (wr_rst && unlocked) reset_level <= bus_wdata;
      reset_req <= wr_rst && unlocked && bus_wdata[8];
    end
  end

  assign led_out = led_q;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFF_ID):      rd_mux = BOARD_ID;
      ADDR_W'(OFF_LED):     rd_mux = 32'(led_q);
      ADDR_W'(OFF_LOCK):    rd_mux = 32'(lock_q);
      ADDR_W'(OFF_CFG0):    rd_mux = cfg0_q;
      ADDR_W'(OFF_CFG1):    rd_mux = cfg1_q;
      ADDR_W'(OFF_FLG_SET): rd_mux = flags_q;
      ADDR_W'(OFF_NVF_SET): rd_mux = nvflags_q;
      ADDR_W'(OFF_RSTCTL):  rd_mux = reset_level;
      ADDR_W'(OFF_CONST_A): rd_mux = VAL_CONST_A;
      ADDR_W'(OFF_CONST_B): rd_mux = VAL_CONST_B;
      ADDR_W'(OFF_TICK):    rd_mux = 32'(tick_q);
      ADDR_W'(OFF_CONST_C): rd_mux = VAL_CONST_C;
      ADDR_W'(OFF_CONST_D): rd_mux = VAL_CONST_D;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_mux;
  end

  // R7: a reset control write while locked leaves the level untouched
  a_r7_locked_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_rst && !unlocked) |=> $stable(reset_level));
  // R8: a request only follows an accepted write with data bit 8 set
  a_r8_req_cause: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(wr_rst && unlocked && bus_wdata[8]));
  // R12: read data holds when no read is presented
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(bus_rdata));
endmodule

// File: tb/board_sysctl_bench.sv
`timescale 1ns/1ps
module board_sysctl_bench;
  localparam logic [31:0] ID = 32'h1234_5678;
  localparam int NV = 34;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_out;
  logic        reset_req;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  board_sysctl #(
    .BOARD_ID(ID), .LED_W(8), .ADDR_W(12),
    .CLK_HZ(96), .TICK_HZ(24), .CNT_W(6)
  ) u_board_sysctl (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_out(led_out), .reset_req(reset_req)
  );

  // {we, addr, wdata, expected read}
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, ID},                        // R1
    {1'b0, 12'h030, 32'h0, 32'h0000_0003},             // R4 reset value
    {1'b1, 12'h030, 32'h0000_00F0, 32'h0},
    {1'b0, 12'h030, 32'h0, 32'h0000_00F3},             // R4 set
    {1'b1, 12'h034, 32'h0000_0011, 32'h0},
    {1'b0, 12'h030, 32'h0, 32'h0000_00E2},             // R4 clear
    {1'b1, 12'h038, 32'h0000_00A5, 32'h0},
    {1'b1, 12'h03C, 32'h0000_0005, 32'h0},
    {1'b0, 12'h038, 32'h0, 32'h0000_00A0},             // R5
    {1'b1, 12'h008, 32'h0000_1234, 32'h0},
    {1'b0, 12'h008, 32'h0, 32'h0000_0034},             // R2
    {1'b1, 12'h028, 32'hDEAD_BEEF, 32'h0},
    {1'b1, 12'h02C, 32'h0123_4567, 32'h0},
    {1'b0, 12'h028, 32'h0, 32'hDEAD_BEEF},             // R3
    {1'b0, 12'h02C, 32'h0, 32'h0123_4567},             // R3
    {1'b0, 12'h044, 32'h0, 32'h0000_0001},             // R1
    {1'b0, 12'h050, 32'h0, 32'h0000_1000},             // R1
    {1'b0, 12'h084, 32'h0, 32'h0200_0000},             // R1
    {1'b0, 12'h088, 32'h0, 32'hFF00_0000},             // R1
    {1'b1, 12'h060, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h060, 32'h0, 32'h0},                     // R10
    {1'b0, 12'h034, 32'h0, 32'h0},                     // R10
    {1'b1, 12'h020, 32'h0001_FFFF, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_7FFF},             // R6
    {1'b1, 12'h040, 32'h0000_0055, 32'h0},
    {1'b0, 12'h040, 32'h0, 32'h0},                     // R7 locked
    {1'b1, 12'h020, 32'h0000_A05F, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_A05F},             // R6 key
    {1'b1, 12'h040, 32'h0000_00AA, 32'h0},
    {1'b0, 12'h040, 32'h0, 32'h0000_00AA},             // R7 unlocked
    {1'b1, 12'h020, 32'h0001_A05F, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_205F},             // R6 near-key
    {1'b1, 12'h040, 32'h0000_0077, 32'h0},
    {1'b0, 12'h040, 32'h0, 32'h0000_00AA}              // R7 relocked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] a, b, c;
    int pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 rdata after reset", bus_rdata, 32'h0);
    chk("R11 led after reset", 32'(led_out), 32'h0);
    chk("R8 no request at reset", 32'(reset_req), 32'h0);

    pulses = 0;
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][76], VEC[i][75:64], VEC[i][63:32]);
      if (reset_req) pulses++;
      if (!VEC[i][76]) chk($sformatf("vector %0d", i), bus_rdata, VEC[i][31:0]);
    end
    chk("R8 no request without bit 8", 32'(pulses), 32'h0);
    chk("R2 led port", 32'(led_out), 32'h34);

    // R12: rdata holds across writes and idle cycles
    access(1'b0, 12'h050, 32'h0);
    access(1'b1, 12'h028, 32'h5555_5555);
    repeat (3) @(negedge clk);
    chk("R12 hold", bus_rdata, 32'h0000_1000);

    // R10: unaligned address reads zero and write is dropped
    access(1'b1, 12'h029, 32'hFFFF_FFFF);
    access(1'b0, 12'h029, 32'h0);
    chk("R10 unaligned read", bus_rdata, 32'h0);
    access(1'b0, 12'h028, 32'h0);
    chk("R10 unaligned write ignored", bus_rdata, 32'h5555_5555);

    // R8: accepted write with bit 8 pulses once
    access(1'b1, 12'h020, 32'h0000_A05F);
    access(1'b1, 12'h040, 32'h0000_0100);
    chk("R8 pulse high", 32'(reset_req), 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(reset_req), 32'h0);
    access(1'b0, 12'h040, 32'h0);
    chk("R7 level stored", bus_rdata, 32'h0000_0100);
    access(1'b1, 12'h020, 32'h0);
    access(1'b1, 12'h040, 32'h0000_0100);
    chk("R8 locked no pulse", 32'(reset_req), 32'h0);

    // R9: counter rate and wrap (divide 4, 6-bit counter)
    access(1'b0, 12'h05C, 32'h0);
    a = bus_rdata;
    repeat (11) @(negedge clk);
    access(1'b0, 12'h05C, 32'h0);
    b = bus_rdata;
    chk("R9 rate", (b - a) & 32'h3F, 32'h3);
    chk("R9 width", b & 32'hFFFF_FFC0, 32'h0);
    repeat (255) @(negedge clk);
    access(1'b0, 12'h05C, 32'h0);
    c = bus_rdata;
    chk("R9 wrap", c, b);

    // R11: mid-run reset
    access(1'b1, 12'h038, 32'h0000_00FF);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R11 rdata cleared", bus_rdata, 32'h0);
    chk("R11 led cleared", 32'(led_out), 32'h0);
    access(1'b0, 12'h030, 32'h0);
    chk("R11 flags load 3", bus_rdata, 32'h3);
    access(1'b0, 12'h038, 32'h0);
    chk("R11 nv flags cleared", bus_rdata, 32'h0);
    access(1'b0, 12'h028, 32'h0);
    chk("R11 cfg cleared", bus_rdata, 32'h0);
    access(1'b0, 12'h040, 32'h0);
    chk("R11 reset level cleared", bus_rdata, 32'h0);
    access(1'b0, 12'h000, 32'h0);
    chk("R1 id after reset", bus_rdata, ID);

    finish_run();
  end
endmodule